// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration registers. A system controller uses it to change control fields and enables after power-up. Every register also appears on a flat parallel output bus, so the neighbouring logic sees the current settings at all times. All registers come out of reset with a parameterized default pattern. The device is therefore fully usable without any serial traffic.

The controller chooses between single-register access and sequential block access with a command byte. In block mode the transfer always starts at register 0. A block write carries a byte count before the data. A block read returns the register count first and then the register contents. The block oversamples SCL and SDA with its own system clock. It pulls SDA low through an output enable, and the bus resistor supplies the high level.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only if its upper seven bits equal the ADDR7 parameter (default 7'h69, so the bytes are D2h for write and D3h for read). A read address is acknowledged only after an accepted command byte in the same transaction. Any other address byte gets NACK, and the slave stays silent until the next START.
- R2: Bit 7 of the command byte selects the access type: 1 means a single-register access at the offset in bits 4:0, and 0 means a block access starting at register 0. In single-register write mode only the first data byte is stored. Later data bytes are acknowledged and dropped.
- R3: If command bits 6:5 are not 00, the command byte is NACKed. The slave then NACKs every following byte, leaves the registers unchanged, and stays silent until the next START.
- R4: A block write takes a byte count after the command and then stores data bytes into ascending registers. Data bytes beyond the count are acknowledged and discarded.
- R5: A block read returns NREG as the first byte. It then returns register 0, register 1 and so on, with each byte sent most significant bit first.
- R6: A STOP after any complete data byte ends the transfer. Every byte written before the STOP stays stored.
- R7: A byte written to an offset at or above NREG is acknowledged and discarded. A read from such an offset returns FFh.
- R8: After reset, register i holds bits 8i+7:8i of the DEFAULTS parameter. SDA is released.
- R9: When the master answers a read byte with NACK, the slave releases SDA and sends nothing more until the next START.
- R10: The slave changes its SDA drive only while SCL is low. A START condition returns it to address reception, and a STOP condition returns it to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pulls SDA low |
| regs_o | output | NREG*8 | Register bank; register i occupies bits 8i+7:8i |

## Verification
On every cycle the assertions check three things. SDA drive never moves while SCL stays high, START and STOP force the slave's state, and an ignoring slave never drives the bus. They also check that the register outputs change only while a write data byte is being taken. Only the bench scenarios can show the end-to-end behaviour: that the right bytes land in the right registers, that the byte count and the out-of-range rules discard the correct bytes, that a block read returns the count and then the data in order, and that the acknowledge pattern a master observes is correct for wrong addresses and wrong chip-select codes.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int NREG = 8,
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = 64'hF7E6_D5C4_B3A2_9180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int PW = (NREG > 1) ? $clog2(NREG) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WDATA, S_RDATA, S_IGN} st_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic       ackph, blk, cmd_ok, cnt_pend;
  logic [7:0] sh, tx, ptr, left;
  logic [7:0] regs [NREG];

  wire scl = scl_q[1];
  wire sda = sda_q[1];
  wire scl_rise  = scl & ~scl_q[2];
  wire scl_fall  = ~scl & scl_q[2];
  wire start_det = scl & scl_q[2] & sda_q[2] & ~sda;
  wire stop_det  = scl & scl_q[2] & ~sda_q[2] & sda;
  wire in_range  = ptr < 8'(NREG);
  wire [7:0] rd_byte = in_range ? regs[ptr[PW-1:0]] : 8'hFF;
  wire [7:0] nxt_tx  = cnt_pend ? 8'(NREG) : rd_byte;
  wire [7:0] ptr_inc = (ptr == 8'hFF) ? ptr : ptr + 8'd1;

  for (genvar i = 0; i < NREG; i++) begin : g_out
    assign regs_o[i*8 +: 8] = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      ackph <= 1'b0;
      blk <= 1'b0;
      cmd_ok <= 1'b0;
      cnt_pend <= 1'b0;
      sh <= '0;
      tx <= '0;
      ptr <= '0;
      left <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= DEFAULTS[i*8 +: 8];
    end else if (start_det) begin
      st <= S_ADDR;
      bitcnt <= '0;
      ackph <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st <= S_IDLE;
      ackph <= 1'b0;
      cmd_ok <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE && st != S_IGN) begin
      if (scl_rise) begin
        if (!ackph) begin
          sh <= {sh[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (st == S_RDATA && sda) begin
          st <= S_IGN;
        end
      end else if (scl_fall) begin
        if (!ackph && bitcnt == 4'd8) begin
          ackph <= 1'b1;
          sda_oe <= 1'b0;
          case (st)
            S_ADDR: begin
              if (sh[7:1] == ADDR7 && (!sh[0] || cmd_ok)) begin
                sda_oe <= 1'b1;
                st <= sh[0] ? S_RDATA : S_CMD;
                cnt_pend <= sh[0] & blk;
              end else begin
                st <= S_IGN;
              end
            end
            S_CMD: begin
              if (sh[6:5] == 2'b00) begin
                sda_oe <= 1'b1;
                blk <= ~sh[7];
                ptr <= sh[7] ? {3'b000, sh[4:0]} : 8'd0;
                left <= 8'd1;
                cmd_ok <= 1'b1;
                st <= sh[7] ? S_WDATA : S_CNT;
              end else begin
                cmd_ok <= 1'b0;
                st <= S_IGN;
              end
            end
            S_CNT: begin
              sda_oe <= 1'b1;
              left <= sh;
              st <= S_WDATA;
            end
            S_WDATA: begin
              sda_oe <= 1'b1;
              if (left != 8'd0 && in_range) regs[ptr[PW-1:0]] <= sh;
              if (left != 8'd0) left <= left - 8'd1;
              ptr <= ptr_inc;
            end
            default: ;
          endcase
        end else if (ackph) begin
          ackph <= 1'b0;
          bitcnt <= '0;
          if (st == S_RDATA) begin
            tx <= nxt_tx;
            sda_oe <= ~nxt_tx[7];
            if (cnt_pend) cnt_pend <= 1'b0;
            else ptr <= ptr_inc;
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (st == S_RDATA) begin
          sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_lvl,
  input logic            sda_oe,
  input logic            start_det,
  input logic            stop_det,
  input logic [2:0]      st,
  input logic [NREG*8-1:0] regs_o
);
  localparam logic [2:0] C_IDLE = 3'd0, C_ADDR = 3'd1, C_WDATA = 3'd4, C_IGN = 3'd6;

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == C_ADDR));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == C_IDLE && !sda_oe));

  // R3
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IGN) |-> !sda_oe);

  // R4
  reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> ($past(st) == C_WDATA));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_q[1]), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .st(st), .regs_o(regs_o)
);

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
  localparam int NREG = 8;
  localparam logic [NREG*8-1:0] DEF = 64'hF7E6_D5C4_B3A2_9180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire sda_bus = !(m_low || sda_oe);
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  smb_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
                    .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regs_chk(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 64'(regs_o[i*8 +: 8]), 64'(model[i]));
  endtask

  task automatic q;
    repeat (10) @(negedge clk);
  endtask

  task automatic bstart;
    m_low = 1'b0; q; m_scl = 1'b1; q; m_low = 1'b1; q; m_scl = 1'b0; q;
  endtask

  task automatic bstop;
    m_low = 1'b1; q; m_scl = 1'b1; q; m_low = 1'b0; q;
  endtask

  task automatic wbit(input logic b);
    m_low = !b; q; m_scl = 1'b1; q; m_scl = 1'b0; q;
  endtask

  task automatic rbit(output logic b);
    m_low = 1'b0; q; m_scl = 1'b1; q; b = sda_bus; m_scl = 1'b0; q;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(nack);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NREG; i++) model[i] = DEF[i*8 +: 8];
    regs_chk("R8 defaults");
    chk("R8 sda released", 64'(sda_oe), 64'd0);
  endtask

  task automatic t_bad_addr;
    logic a;
    bstart; wbyte(8'hD4, a); chk("R1 foreign address nack", 64'(a), 64'd0);
    wbyte(8'h83, a); chk("R1 silent after foreign address", 64'(a), 64'd0);
    bstop;
    bstart; wbyte(8'hD3, a); chk("R1 read without command nack", 64'(a), 64'd0);
    bstop;
  endtask

  task automatic t_byte_wr;
    logic a;
    bstart; wbyte(8'hD2, a); chk("R1 own address ack", 64'(a), 64'd1);
    wbyte(8'h83, a); chk("R2 byte command ack", 64'(a), 64'd1);
    wbyte(8'hA5, a); chk("R2 data ack", 64'(a), 64'd1);
    wbyte(8'h3C, a); chk("R2 extra byte ack", 64'(a), 64'd1);
    bstop;
    model[3] = 8'hA5;
    regs_chk("R2 single write, extra dropped");
  endtask

  task automatic t_byte_rd(input logic [4:0] off, input logic [7:0] exp, input string req);
    logic a;
    logic [7:0] d;
    bstart; wbyte(8'hD2, a); wbyte({3'b100, off}, a);
    bstart; wbyte(8'hD3, a); chk({req, " read address ack"}, 64'(a), 64'd1);
    rbyte(1'b1, d); chk({req, " read data"}, 64'(d), 64'(exp));
    chk("R9 released after master nack", 64'(sda_oe), 64'd0);
    q;
    chk("R9 still released", 64'(sda_oe), 64'd0);
    bstop;
  endtask

  task automatic t_blk_wr(input logic [7:0] cnt, input int nbytes, input logic [7:0] base,
                          input string req);
    logic a;
    bstart; wbyte(8'hD2, a); wbyte(8'h00, a); chk({req, " block command ack"}, 64'(a), 64'd1);
    wbyte(cnt, a); chk({req, " count ack"}, 64'(a), 64'd1);
    for (int i = 0; i < nbytes; i++) begin
      wbyte(base + 8'(i * 17), a);
      chk({req, " data ack"}, 64'(a), 64'd1);
      if (i < int'(cnt) && i < NREG) model[i] = base + 8'(i * 17);
    end
    bstop;
    regs_chk(req);
  endtask

  task automatic t_bad_cs;
    logic a;
    bstart; wbyte(8'hD2, a); wbyte(8'hA1, a); chk("R3 chip select nack", 64'(a), 64'd0);
    wbyte(8'h99, a); chk("R3 following byte nack", 64'(a), 64'd0);
    bstop;
    regs_chk("R3 registers untouched");
  endtask

  task automatic t_range;
    logic a;
    bstart; wbyte(8'hD2, a); wbyte(8'h94, a); chk("R7 high offset command ack", 64'(a), 64'd1);
    wbyte(8'h77, a); chk("R7 high offset data ack", 64'(a), 64'd1);
    bstop;
    regs_chk("R7 high offset discarded");
    t_byte_rd(5'd20, 8'hFF, "R7");
  endtask

  task automatic t_blk_rd;
    logic a;
    logic [7:0] d;
    bstart; wbyte(8'hD2, a); wbyte(8'h00, a);
    bstart; wbyte(8'hD3, a); chk("R5 block read address ack", 64'(a), 64'd1);
    rbyte(1'b0, d); chk("R5 count byte", 64'(d), 64'(NREG));
    for (int i = 0; i < NREG; i++) begin
      rbyte(i == NREG - 1, d);
      chk("R5 block read data", 64'(d), 64'(model[i]));
    end
    chk("R9 released after last byte", 64'(sda_oe), 64'd0);
    bstop;
  endtask

  task automatic t_stop_mid;
    logic a;
    bstart; wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'd4, a); wbyte(8'hEE, a);
    bstop;
    model[0] = 8'hEE;
    regs_chk("R6 committed before stop");
    chk("R10 idle after stop", 64'(sda_oe), 64'd0);
    t_byte_rd(5'd0, 8'hEE, "R6");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_bad_addr;
    t_byte_wr;
    t_byte_rd(5'd3, 8'hA5, "R2");
    t_byte_rd(5'd7, 8'hF7, "R8");
    t_blk_wr(8'd3, 3, 8'h11, "R4 block write");
    t_blk_wr(8'd2, 3, 8'h44, "R4 beyond count");
    t_bad_cs;
    t_range;
    t_blk_rd;
    t_stop_mid;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule